// File: doc/BRIEF.md
# Cartridge Bank Latch

This block sits on an 8-bit CPU bus and selects memory banks for a cartridge. It decodes a few register addresses in the low address space. It holds a small internal register set: a 4-bit counter field, a 2-bit high field, a 4-bit staging field, an increment-mode flag and an invert flag. Writes to the low registers stage values inside the block, and a global invert flag is XORed into several paths. A separate write anywhere in the upper address space copies the internal state to a 5-bit bank output.

The block also lets the CPU read back part of its register set. A small combinational relay passes one of two auxiliary inputs to an output pin, selected by the invert flag. A second pin ORs that relay output with data bit 5. The block runs from a system clock. The bus strobe M2 is sampled on that clock, and writes commit on a detected falling edge of M2.

Address decode for the low registers requires all of the following:
- ROM select high, which marks address bit 15 as 0.
- A14 high.
- A13 low.
- A8 high.

A1:A0 then pick the register: 00 step, 01 invert, 10 load, 11 mode.

Top module: `bank_latch_chip`

## Requirements
- R1: After reset the counter, high, staging, mode and invert state and the bank output are all zero. A readback then returns 0 on data_hi_o and on data_lo_o.
- R2: A write with A1:A0=01 sets the invert flag from data bit 0 (data_lo_i[0]).
- R3: A write with A1:A0=11 sets the increment-mode flag from data bit 0.
- R4: A write with A1:A0=10 does three things. It loads D5:D4 (data_hi_i) into the high field and D2:D0 (data_lo_i) into staging bits 2:0. It also toggles staging bit 3 when the invert flag is set.
- R5: A write with A1:A0=00 and increment mode clear loads the counter with the staging field XOR {4{invert}}.
- R6: A write with A1:A0=00 and increment mode set adds one to the counter modulo 16. The high field is left unchanged.
- R7: A read decoded with A1:A0 ignored drives the data pins as follows. data_hi_o (D5:D4) gets the high field XOR invert. data_lo_o (D2:D0) gets counter bits 2:0. D3, D7 and D6 have no output pin.
- R8: data_oe_o is high only while M2 is high, R/W is high and the low-register decode matches.
- R9: A write with ROM select low loads the bank output: bank_o[3:0] gets the counter, and bank_o[4] gets high bit 0 XOR invert.
- R10: Writes take effect only on a falling edge of M2. Holding M2 high with R/W low changes nothing. A write whose address fails the decode (A8 low or A13 high) has no effect.
- R11: relay_o equals aux0_i while the invert flag is clear, and aux1_i while it is set.
- R12: merge_o equals relay_o OR the bus value of D5. The bus value is data_hi_o[1] while the block drives the bus, and data_hi_i[1] otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| m2_i | input | 1 | CPU bus phase strobe |
| rw_i | input | 1 | CPU read (1) / write (0) |
| romsel_ni | input | 1 | Active-low ROM select (A15 decode) |
| cpu_a0_i | input | 1 | Address bit 0 |
| cpu_a1_i | input | 1 | Address bit 1 |
| cpu_a8_i | input | 1 | Address bit 8 |
| cpu_a13_i | input | 1 | Address bit 13 |
| cpu_a14_i | input | 1 | Address bit 14 |
| data_hi_i | input | 2 | Bus data bits D5:D4 in |
| data_lo_i | input | 3 | Bus data bits D2:D0 in |
| data_hi_o | output | 2 | Readback D5:D4 |
| data_lo_o | output | 3 | Readback D2:D0 |
| data_oe_o | output | 1 | Drive enable for readback pins |
| aux0_i | input | 1 | Auxiliary relay input 0 |
| aux1_i | input | 1 | Auxiliary relay input 1 |
| relay_o | output | 1 | Selected auxiliary input |
| merge_o | output | 1 | relay_o OR bus D5 |
| bank_o | output | 5 | Bank select latch |

## Verification
The assertions assume the following about the inputs:
- M2 is slow compared with the system clock and holds each level for at least one clock.
- The address and R/W inputs are stable around each falling edge of M2.

Under these assumptions a change of the bank latch or the invert flag can be traced to a decoded write strobe in the previous cycle. The stimulus drives every bus cycle on the falling clock edge, with M2 high for one full clock and then low. The stimulus mixes random register writes, reads, ROM-space writes, misdecoded writes and auxiliary pin changes with directed cases: counter wrap, invert toggling of staging bit 3, and a write held with M2 high.

// File: rtl/bank_latch_pkg.sv
package bank_latch_pkg;
  typedef struct packed {
    logic step;
    logic invert;
    logic load;
    logic mode;
    logic bank;
  } wr_stb_t;
endpackage

// File: rtl/bl_bus_decode.sv
module bl_bus_decode
  import bank_latch_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    m2_i,
  input  logic    rw_i,
  input  logic    romsel_ni,
  input  logic    a0_i,
  input  logic    a1_i,
  input  logic    a8_i,
  input  logic    a13_i,
  input  logic    a14_i,
  output wr_stb_t wr_o,
  output logic    rd_o
);
  logic m2_q;
  logic low_hit;
  logic wr_cyc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) m2_q <= 1'b0;
    else         m2_q <= m2_i;
  end

  // commit point: M2 falling edge with R/W low
  assign wr_cyc  = m2_q & ~m2_i & ~rw_i;
  assign low_hit = romsel_ni & a14_i & ~a13_i & a8_i;

  always_comb begin
    wr_o.step   = wr_cyc & low_hit & ~a1_i & ~a0_i;
    wr_o.invert = wr_cyc & low_hit & ~a1_i &  a0_i;
    wr_o.load   = wr_cyc & low_hit &  a1_i & ~a0_i;
    wr_o.mode   = wr_cyc & low_hit &  a1_i &  a0_i;
    wr_o.bank   = wr_cyc & ~romsel_ni;
  end

  assign rd_o = m2_i & rw_i & low_hit;
endmodule

// File: rtl/bl_reg_file.sv
module bl_reg_file
  import bank_latch_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int HI_W  = 2,
  parameter int LO_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  wr_stb_t          wr_i,
  input  logic             flag_bit_i,
  input  logic [HI_W-1:0]  d_hi_i,
  input  logic [LO_W-1:0]  d_lo_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [HI_W-1:0]  hi_o,
  output logic             inc_o,
  output logic             inv_o
);
  localparam int STG_HI = CNT_W - LO_W;

  logic [CNT_W-1:0] cnt_q, stg_q;
  logic [HI_W-1:0]  hi_q;
  logic             inc_q, inv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      stg_q <= '0;
      hi_q  <= '0;
      inc_q <= 1'b0;
      inv_q <= 1'b0;
    end else begin
      if (wr_i.mode)   inc_q <= flag_bit_i;
      if (wr_i.invert) inv_q <= flag_bit_i;
      if (wr_i.load) begin
        hi_q              <= d_hi_i;
        stg_q[LO_W-1:0]   <= d_lo_i;
        stg_q[CNT_W-1:LO_W] <= stg_q[CNT_W-1:LO_W] ^ {STG_HI{inv_q}};
      end
      if (wr_i.step) begin
        if (inc_q) cnt_q <= cnt_q + 1'b1;
        else       cnt_q <= stg_q ^ {CNT_W{inv_q}};
      end
    end
  end

  assign cnt_o = cnt_q;
  assign hi_o  = hi_q;
  assign inc_o = inc_q;
  assign inv_o = inv_q;
endmodule

// File: rtl/bl_bank_latch.sv
module bl_bank_latch #(
  parameter int CNT_W = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic           top_i,
  output logic [CNT_W:0] bank_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bank_o <= '0;
    else if (load_i) bank_o <= {top_i, cnt_i};
  end
endmodule

// File: rtl/bank_latch_chip.sv
module bank_latch_chip
  import bank_latch_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int HI_W  = 2,
  parameter int LO_W  = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            m2_i,
  input  logic            rw_i,
  input  logic            romsel_ni,
  input  logic            cpu_a0_i,
  input  logic            cpu_a1_i,
  input  logic            cpu_a8_i,
  input  logic            cpu_a13_i,
  input  logic            cpu_a14_i,
  input  logic [HI_W-1:0] data_hi_i,
  input  logic [LO_W-1:0] data_lo_i,
  output logic [HI_W-1:0] data_hi_o,
  output logic [LO_W-1:0] data_lo_o,
  output logic            data_oe_o,
  input  logic            aux0_i,
  input  logic            aux1_i,
  output logic            relay_o,
  output logic            merge_o,
  output logic [CNT_W:0]  bank_o
);
  wr_stb_t          wr_stb;
  logic             rd_en;
  logic [CNT_W-1:0] cnt_q;
  logic [HI_W-1:0]  hi_q;
  logic             inc_q, inv_q;
  logic             bus_d5;

  bl_bus_decode u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .m2_i(m2_i), .rw_i(rw_i),
    .romsel_ni(romsel_ni), .a0_i(cpu_a0_i), .a1_i(cpu_a1_i),
    .a8_i(cpu_a8_i), .a13_i(cpu_a13_i), .a14_i(cpu_a14_i),
    .wr_o(wr_stb), .rd_o(rd_en)
  );

  bl_reg_file #(.CNT_W(CNT_W), .HI_W(HI_W), .LO_W(LO_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_stb),
    .flag_bit_i(data_lo_i[0]), .d_hi_i(data_hi_i), .d_lo_i(data_lo_i),
    .cnt_o(cnt_q), .hi_o(hi_q), .inc_o(inc_q), .inv_o(inv_q)
  );

  bl_bank_latch #(.CNT_W(CNT_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(wr_stb.bank),
    .cnt_i(cnt_q), .top_i(hi_q[0] ^ inv_q), .bank_o(bank_o)
  );

  // readback path
  assign data_oe_o = rd_en;
  assign data_hi_o = hi_q ^ {HI_W{inv_q}};
  assign data_lo_o = cnt_q[LO_W-1:0];

  // auxiliary relay; bus D5 is whatever is on the wire
  assign relay_o = inv_q ? aux1_i : aux0_i;
  assign bus_d5  = data_oe_o ? data_hi_o[HI_W-1] : data_hi_i[HI_W-1];
  assign merge_o = relay_o | bus_d5;
endmodule

// File: rtl/bank_latch_chk.sv
module bank_latch_chk #(
  parameter int CNT_W = 4,
  parameter int HI_W  = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             m2_i,
  input logic             rw_i,
  input logic             romsel_ni,
  input logic             a8_i,
  input logic             a13_i,
  input logic             a14_i,
  input logic             data_oe_i,
  input logic             aux0_i,
  input logic             aux1_i,
  input logic             relay_i,
  input logic             merge_i,
  input logic [CNT_W:0]   bank_i,
  input logic             step_stb_i,
  input logic             inv_stb_i,
  input logic             inc_i,
  input logic             inv_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [HI_W-1:0]  hi_i
);
  logic m2_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) m2_d <= 1'b0;
    else         m2_d <= m2_i;
  end

  a_r8_bus_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(m2_i && rw_i && romsel_ni && a14_i && !a13_i && a8_i) |-> !data_oe_i);

  a_r9_bank_only_on_rom_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bank_i) |-> $past(m2_d && !m2_i && !rw_i && !romsel_ni));

  a_r2_invert_only_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(inv_i) |-> $past(inv_stb_i));

  a_r6_step_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_stb_i && inc_i) |=> (cnt_i == $past(cnt_i) + 1'b1) && $stable(hi_i));

  a_r11_relay_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux0_i == aux1_i) |-> (relay_i == aux0_i));

  a_r12_merge_covers_relay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    relay_i |-> merge_i);
endmodule

bind bank_latch_chip bank_latch_chk #(.CNT_W(CNT_W), .HI_W(HI_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .m2_i(m2_i), .rw_i(rw_i),
  .romsel_ni(romsel_ni), .a8_i(cpu_a8_i), .a13_i(cpu_a13_i), .a14_i(cpu_a14_i),
  .data_oe_i(data_oe_o), .aux0_i(aux0_i), .aux1_i(aux1_i),
  .relay_i(relay_o), .merge_i(merge_o), .bank_i(bank_o),
  .step_stb_i(wr_stb.step), .inv_stb_i(wr_stb.invert),
  .inc_i(inc_q), .inv_i(inv_q), .cnt_i(cnt_q), .hi_i(hi_q)
);

// File: tb/sim_bank_latch_chip.sv
module sim_bank_latch_chip;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic m2 = 1'b0, rw = 1'b1, romsel_n = 1'b1;
  logic a0 = 0, a1 = 0, a8 = 0, a13 = 0, a14 = 0;
  logic [1:0] dhi = '0;
  logic [2:0] dlo = '0;
  logic aux0 = 0, aux1 = 0;
  logic [1:0] qhi;
  logic [2:0] qlo;
  logic oe, relay, merge;
  logic [4:0] bank;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  logic [3:0] m_cnt = 0, m_stg = 0;
  logic [1:0] m_hi = 0;
  logic m_inc = 0, m_inv = 0;
  logic [4:0] m_bank = 0;

  always #2 clk = ~clk;

  bank_latch_chip u0 (
    .clk_i(clk), .rst_ni(rst_ni), .m2_i(m2), .rw_i(rw), .romsel_ni(romsel_n),
    .cpu_a0_i(a0), .cpu_a1_i(a1), .cpu_a8_i(a8), .cpu_a13_i(a13), .cpu_a14_i(a14),
    .data_hi_i(dhi), .data_lo_i(dlo), .data_hi_o(qhi), .data_lo_o(qlo),
    .data_oe_o(oe), .aux0_i(aux0), .aux1_i(aux1), .relay_o(relay),
    .merge_o(merge), .bank_o(bank)
  );

  function automatic logic [1:0] exp_hi();
    return m_hi ^ {2{m_inv}};
  endfunction
  function automatic logic exp_relay();
    return m_inv ? aux1 : aux0;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_addr(input logic [15:0] a);
    a0 = a[0]; a1 = a[1]; a8 = a[8]; a13 = a[13]; a14 = a[14];
    romsel_n = ~a[15];
  endtask

  function automatic bit low_hit(input logic [15:0] a);
    return !a[15] && a[14] && !a[13] && a[8];
  endfunction

  task automatic model_write(input logic [15:0] a, input logic [1:0] h, input logic [2:0] l);
    if (a[15]) m_bank = {m_hi[0] ^ m_inv, m_cnt};
    else if (low_hit(a)) begin
      case (a[1:0])
        2'b01: m_inv = l[0];
        2'b11: m_inc = l[0];
        2'b10: begin m_hi = h; m_stg = {m_stg[3] ^ m_inv, l}; end
        default: m_cnt = m_inc ? m_cnt + 4'd1 : m_stg ^ {4{m_inv}};
      endcase
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [1:0] h, input logic [2:0] l);
    @(negedge clk); set_addr(a); rw = 0; dhi = h; dlo = l; m2 = 1;
    @(negedge clk); m2 = 0;
    @(negedge clk); rw = 1; romsel_n = 1;
    model_write(a, h, l);
  endtask

  task automatic bus_read(input logic [15:0] a);
    @(negedge clk); set_addr(a); rw = 1; m2 = 1;
    #1;
    chk("R7 oe", {7'd0, oe}, 8'd1);
    chk("R7 data", {3'd0, qhi, qlo}, {3'd0, exp_hi(), m_cnt[2:0]});
    chk("R12 merge during read", {7'd0, merge}, {7'd0, exp_relay() | exp_hi()[1]});
    @(negedge clk); m2 = 0;
    #1 chk("R8 release", {7'd0, oe}, 8'd0);
    romsel_n = 1;
  endtask

  task automatic idle_checks();
    @(negedge clk); #1;
    chk("R9 bank", {3'd0, bank}, {3'd0, m_bank});
    chk("R11 relay", {7'd0, relay}, {7'd0, exp_relay()});
    chk("R12 merge", {7'd0, merge}, {7'd0, exp_relay() | dhi[1]});
    chk("R8 idle", {7'd0, oe}, 8'd0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1 reset state
    idle_checks();
    chk("R1 bank", {3'd0, bank}, 8'd0);
    bus_read(16'h4100);

    // R2/R3/R4/R5 directed
    bus_write(16'h4102, 2'b10, 3'b101);        // R4 load
    bus_write(16'h4100, 2'b00, 3'b000);        // R5 load cnt = stg
    bus_read(16'h4103);
    bus_write(16'h4101, 2'b00, 3'b001);        // R2 invert on
    idle_checks();
    bus_write(16'h4102, 2'b01, 3'b010);        // R4 stg bit3 toggles
    bus_write(16'h4100, 2'b00, 3'b000);        // R5 cnt = stg ^ 1111
    bus_read(16'h4101);
    chk("R4 stg3 via R5", {4'd0, m_cnt}, {4'd0, ~4'b1010});
    // R6 wrap: force cnt 15 then increment
    bus_write(16'h4101, 2'b00, 3'b000);
    bus_write(16'h4102, 2'b00, 3'b111);        // stg = 1111 (bit3 toggled earlier)
    bus_write(16'h4100, 2'b00, 3'b000);
    bus_write(16'h4103, 2'b00, 3'b001);        // R3 inc mode
    bus_write(16'h4100, 2'b00, 3'b000);        // R6 15 -> 0
    bus_read(16'h4100);
    chk("R6 wrap", {4'd0, m_cnt}, 8'd0);
    bus_write(16'hC000, 2'b00, 3'b000);        // R9 bank latch
    idle_checks();

    // R10 held M2 high: no commit until fall
    @(negedge clk); set_addr(16'h4101); rw = 0; dlo = 3'b001; m2 = 1; aux0 = 0; aux1 = 1;
    repeat (3) @(negedge clk);
    #1 chk("R10 no commit while M2 high", {7'd0, relay}, 8'd0);
    m2 = 0;
    @(negedge clk); rw = 1; romsel_n = 1;
    #1 chk("R10 commit on fall", {7'd0, relay}, 8'd1);
    model_write(16'h4101, 2'b00, 3'b001);
    // R10 misdecoded writes ignored
    bus_write(16'h4001, 2'b00, 3'b000);        // A8 low
    bus_write(16'h6101, 2'b00, 3'b000);        // A13 high
    #1 chk("R10 misdecode ignored", {7'd0, relay}, 8'd1);
    m_inv = 1;

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      int op;
      op = $urandom_range(0, 7);
      aux0 = 1'($urandom); aux1 = 1'($urandom);
      case (op)
        0: a = 16'h4100;
        1: a = 16'h4101;
        2: a = 16'h4102;
        3: a = 16'h4103;
        4: a = 16'h8000 | 16'($urandom_range(0, 16'h7fff));
        5: a = 16'h4000 | 16'($urandom_range(0, 16'h3fff));
        default: a = 16'h4100 | 16'($urandom_range(0, 3));
      endcase
      if (op >= 6) bus_read(a);
      else bus_write(a, 2'($urandom), 3'($urandom));
      dhi = 2'($urandom);
      idle_checks();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule